// File: doc/BRIEF.md
# Center-Aligned PWM Channel

This block is a single pulse-width modulation channel whose pulses are centred in each period. An 8-bit counter counts up from zero to a programmed period value and then back down to zero. Because both halves of the triangle are used, one output period spans twice the period value in counter steps. The output is active while the counter sits below the duty value. It leaves that level when the rising count meets the duty value and returns to it when the falling count meets the duty value again.

Software writes the period and duty values into buffer inputs at any time. The channel copies them into its working registers only when the counter comes back down to zero, so a period in progress is never cut short or stretched. An external prescaler supplies a one-cycle step strobe that paces the counter. A polarity input chooses whether the active level is high or low. While the enable input is low, the counter is parked at zero and the output rests at its inactive level. The buffers are copied on every cycle of that time, so values written before enabling apply from the first step.

Top module: `cpwm_channel`

## Requirements
- R1: While reset (rst_n low, sampled on the clock) is applied, the counter clears and pwm_out settles at the inactive level, which is the inverse of pol.
- R2: With period P>0 the counter advances by one per step, from 0 up to P and then down to 0, turning downward on reaching P and upward on reaching 0, so the output repeats every 2*P steps.
- R3: With 0<D<P, the output is active from the start of the period until the rising count equals D. It becomes active again when the falling count equals D, which gives 2*D active steps out of 2*P.
- R4: pol=1 makes the active level high (1) and the inactive level low (0); pol=0 reverses both levels.
- R5: Values on period_buf and duty_buf reach the working registers only on the step that brings the counter down to 0. A change made mid-period does not alter the current period.
- R6: While en is 0 the counter is held at 0 and pwm_out shows the inactive level. The buffers are copied every cycle, so the settings present before en rises govern the first period.
- R7: The counter and the output pattern advance only in cycles where step_en is 1. In other cycles the counter holds.
- R8: A duty of 0 gives a constant inactive output, and a duty of at least P gives a constant active output.
- R9: A period of 0 keeps the counter at 0 with a constant output: active when the duty is nonzero, inactive when it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Channel enable |
| step_en | input | 1 | Counter step strobe from the prescaler |
| pol | input | 1 | 1: active level high, 0: active level low |
| period_buf | input | 8 | Buffered period value |
| duty_buf | input | 8 | Buffered duty value |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions assume that reset is held for at least one clock before any check applies. They also assume that en, step_en, pol and both buffers change only between clock edges, with the inputs steady across each sampling edge. The bench drives every input just after the falling edge and keeps reset low for several cycles at the start. It writes new buffer values either while the channel is disabled or at an arbitrary point mid-period, and the latter is exactly the case that the load-at-zero property must tolerate. The step pattern is a fixed gating sequence, so stalls fall in both the rising and the falling halves of the count.

// File: rtl/cpwm_channel.sv
module cpwm_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step_en,
  input  logic         pol,
  input  logic [W-1:0] period_buf,
  input  logic [W-1:0] duty_buf,
  output logic         pwm_out
);

  logic [W-1:0] cnt_q, per_q, dty_q;
  logic [W-1:0] cnt_n, per_n, dty_n;
  logic         down_q, down_n;
  logic         out_q, act;

  always_comb begin
    cnt_n  = cnt_q;
    down_n = down_q;
    per_n  = per_q;
    dty_n  = dty_q;
    if (!en) begin
      cnt_n  = '0;
      down_n = 1'b0;
      per_n  = period_buf;
      dty_n  = duty_buf;
    end else if (step_en) begin
      if (per_q == '0)  cnt_n = '0;
      else if (down_q)  cnt_n = cnt_q - 1'b1;
      else              cnt_n = cnt_q + 1'b1;
      if (per_q != '0 && cnt_n == per_q) down_n = 1'b1;
      if (cnt_n == '0) begin
        down_n = 1'b0;
        per_n  = period_buf;
        dty_n  = duty_buf;
      end
    end
  end

  always_comb begin
    if (!en || dty_n == '0) act = 1'b0;
    else if (dty_n >= per_n) act = 1'b1;
    else if (down_n)         act = (cnt_n <= dty_n);
    else                     act = (cnt_n <  dty_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      per_q  <= '0;
      dty_q  <= '0;
      out_q  <= ~pol;
    end else begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
      per_q  <= per_n;
      dty_q  <= dty_n;
      out_q  <= act ~^ pol;
    end
  end

  assign pwm_out = out_q;

endmodule

module cpwm_channel_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         step_en,
  input logic         pol,
  input logic         pwm_out,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] per_q,
  input logic         down_q
);

  a_r2_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);

  a_r2_up_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !down_q);

  a_r5_load_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && per_q != $past(per_q)) |-> (cnt_q == '0));

  a_r6_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && pwm_out == !$past(pol)));

  a_r7_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step_en) |=> (cnt_q == $past(cnt_q) && down_q == $past(down_q)));

  a_r9_zero_period_still: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0) |-> (cnt_q == '0));

endmodule

bind cpwm_channel cpwm_channel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .step_en(step_en), .pol(pol),
  .pwm_out(pwm_out), .cnt_q(cnt_q), .per_q(per_q), .down_q(down_q)
);

// File: tb/tb_cpwm_channel.sv
module tb_cpwm_channel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       step_en = 1'b1;
  logic       pol = 1'b1;
  logic [7:0] period_buf = 8'd0;
  logic [7:0] duty_buf = 8'd0;
  logic       pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit    exp_q[$];
  string tag_q[$];
  int p = 0, mp = 0, md = 0;

  always #5 clk = ~clk;

  cpwm_channel dut (
    .clk(clk), .rst_n(rst_n), .en(en), .step_en(step_en), .pol(pol),
    .period_buf(period_buf), .duty_buf(duty_buf), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string tag, input logic act_v, input logic exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: pwm_out=%b expected=%b at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic load_buf();
    mp = period_buf;
    md = duty_buf;
  endtask

  // Driver: predicts the output after the coming rising edge, then waits a cycle.
  task automatic tick(input string tag);
    bit act;
    if (!en) begin
      p = 0;
      load_buf();
    end else if (step_en) begin
      if (mp == 0) begin
        p = 0;
        load_buf();
      end else begin
        p++;
        if (p == 2 * mp) begin
          p = 0;
          load_buf();
        end
      end
    end
    if (!en || md == 0) act = 1'b0;
    else if (md >= mp)  act = 1'b1;
    else                act = (p < md) || (p >= 2 * mp - md);
    exp_q.push_back(pol ? act : !act);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  // Monitor
  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(pwm_out === e, t, pwm_out, e);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(pwm_out === 1'b0, "R1 reset pol=1", pwm_out, 1'b0);
    @(negedge clk);
    pol = 1'b0;
    @(posedge clk);
    #2;
    check(pwm_out === 1'b1, "R1 reset pol=0", pwm_out, 1'b1);
    @(negedge clk);
    pol = 1'b1;
    rst_n = 1'b1;

    // R6: settings written while disabled govern the first period
    period_buf = 8'd4; duty_buf = 8'd3;
    run(3, "R6 idle");
    en = 1'b1;
    run(24, "R2 R3 P=4 D=3");

    pol = 1'b0;
    run(16, "R4 low active");
    pol = 1'b1;

    // R5: mid-period buffer change
    period_buf = 8'd4; duty_buf = 8'd1;
    run(11, "R5 before change");
    period_buf = 8'd6; duty_buf = 8'd5;
    run(30, "R5 after change");

    // R6: disable mid-run, then restart
    period_buf = 8'd3; duty_buf = 8'd1;
    run(5, "R6 run");
    en = 1'b0;
    run(4, "R6 disabled");
    en = 1'b1;
    run(14, "R6 restart");

    // R7: gated steps
    period_buf = 8'd5; duty_buf = 8'd2;
    for (int i = 0; i < 60; i++) begin
      step_en = (i % 3 != 0);
      tick("R7 gated");
    end
    step_en = 1'b1;

    // R8: duty corner cases
    en = 1'b0; period_buf = 8'd5; duty_buf = 8'd0;
    run(2, "R8 setup");
    en = 1'b1;
    run(14, "R8 duty zero");
    en = 1'b0; duty_buf = 8'd5;
    run(2, "R8 setup");
    en = 1'b1;
    run(14, "R8 duty equal");
    en = 1'b0; duty_buf = 8'd9;
    run(2, "R8 setup");
    en = 1'b1;
    run(14, "R8 duty above");

    // R9: zero period
    en = 1'b0; period_buf = 8'd0; duty_buf = 8'd2;
    run(2, "R9 setup");
    en = 1'b1;
    run(8, "R9 zero period");
    duty_buf = 8'd0;
    run(8, "R9 zero period zero duty");
    period_buf = 8'd2; duty_buf = 8'd1;
    run(12, "R9 leave zero period");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule